// File: doc/BRIEF.md
# Multiply-Step Unit

This block carries out a single iteration of a shift-and-add multiplication, the primitive that a software loop repeats to build a full product from a multiplier held in the Y register. Each accepted step takes a running partial product, shifts it right by one place with the true sign of the previous sum (N XOR V) filling the vacated top bit, and adds the multiplicand only when the lowest Y bit is set. Y is shifted right at the same time and catches the bit that fell out of the partial product. The result, the new Y and a fresh set of 32-bit condition flags are returned together.

Steps enter and leave through valid/ready handshakes with one register stage between them. An input step is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. The result appears on the outputs one cycle later with `out_valid` high. A downstream stall (`out_ready` low while `out_valid` is high) freezes the output register and drops `in_ready`, so back-pressure reaches the producer in the same cycle. Feeding the result, Y, N and V of each step into the next one for thirty-two steps, followed by one extra step with a zero multiplicand, leaves the high product word in the result and the low word in Y. A final subtraction of the multiplicand from the high word, made by the caller when the multiplier is negative, turns this into a signed product.

Top module: `mstep_unit`

## Requirements
- R1: The shifted partial product is `in_op1[W-1:1]` in bits W-2..0, with `in_n XOR in_v` placed in bit W-1.
- R2: The addend is `in_op2` when `in_y[0]` is 1 and zero when it is 0. With `in_y[0]` at 0, the value of `in_op2` has no effect on any output.
- R3: `out_res` equals the shifted partial product plus the addend, modulo 2^W.
- R4: `out_y` equals `in_y` shifted right by one, with `in_op1[0]` placed in bit W-1.
- R5: `out_v` is 1 exactly when the partial product and the addend have the same bit W-1 and the sum's bit W-1 differs from it.
- R6: `out_c` is the carry out of bit W-1 of the W-bit addition.
- R7: `out_n` equals `out_res[W-1]`, and `out_z` is 1 exactly when `out_res` is all zeros.
- R8: A step accepted on one edge is presented with `out_valid` high after that edge. `in_ready` is high whenever the output register is empty or `out_ready` is high. While `out_valid` is high and `out_ready` is low, all outputs hold their values.
- R9: While `rst_n` is low, and right after it is released, `out_valid` is 0 and `in_ready` is 1.
- R10: Thirty-two chained steps (initial partial product 0, N and V 0, Y holding the multiplier, op2 holding the multiplicand) followed by one step with op2 zero give the 64-bit signed product as {result, Y}, once the multiplicand is subtracted from the high word for a negative multiplier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A step is offered |
| in_ready | output | 1 | The unit can take a step this cycle |
| in_op1 | input | W | Running partial product |
| in_op2 | input | W | Multiplicand |
| in_y | input | W | Current Y (multiplier bits) |
| in_n | input | 1 | Current negative flag |
| in_v | input | 1 | Current overflow flag |
| out_valid | output | 1 | A step result is present |
| out_ready | input | 1 | The consumer takes the result this cycle |
| out_res | output | W | New partial product |
| out_y | output | W | New Y |
| out_n | output | 1 | Negative flag of the result |
| out_z | output | 1 | Zero flag of the result |
| out_v | output | 1 | Signed overflow of the addition |
| out_c | output | 1 | Carry out of the addition |

## Verification
The bench aims first at the sign fill. It uses N and V both set, where the fill must be 0, and a lone N, where it must be 1. A design that copied op1's top bit or used N alone would give a wrong top bit and break every negative product. It then holds Y[0] at zero under a large op2, where a missing gate would add the multiplicand anyway, and it drives sums that just cross bit W-1 or wrap to zero, where a swapped carry or overflow equation would show a flipped C or V. Long random runs with stalls on both sides show whether a result is lost or duplicated under back-pressure. The chained product tests, with both operands at the most negative value, would expose an unsigned fill or a Y shift that inserts the wrong bit.

// File: rtl/mstep_pkg.sv
package mstep_pkg;
  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } mstep_flags_t;
endpackage

// File: rtl/mstep_operand.sv
// Forms the shifted partial product and the Y-gated addend.
module mstep_operand #(
  parameter int W = 32
) (
  input  logic [W-2:0] op1_hi,
  input  logic [W-1:0] op2,
  input  logic         y_lsb,
  input  logic         n_flag,
  input  logic         v_flag,
  output logic [W-1:0] partial,
  output logic [W-1:0] addend
);
  always_comb begin
    partial = {n_flag ^ v_flag, op1_hi};
    addend  = y_lsb ? op2 : '0;
  end
endmodule

// File: rtl/mstep_adder.sv
// W-bit addition with the four condition flags.
module mstep_adder
  import mstep_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]  partial,
  input  logic [W-1:0]  addend,
  output logic [W-1:0]  sum,
  output mstep_flags_t  flags
);
  localparam int MSB = W - 1;

  logic [W:0] wide;

  always_comb begin
    wide    = {1'b0, partial} + {1'b0, addend};
    sum     = wide[MSB:0];
    flags.c = wide[W];
    flags.n = wide[MSB];
    flags.z = (wide[MSB:0] == '0);
    flags.v = (partial[MSB] == addend[MSB]) && (wide[MSB] != addend[MSB]);
  end
endmodule

// File: rtl/mstep_yshift.sv
// Shifts Y right, catching the bit dropped from the partial product.
module mstep_yshift #(
  parameter int W = 32
) (
  input  logic [W-2:0] y_hi,
  input  logic         op1_lsb,
  output logic [W-1:0] y_next
);
  always_comb y_next = {op1_lsb, y_hi};
endmodule

// File: rtl/mstep_unit.sv
module mstep_unit
  import mstep_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_op1,
  input  logic [W-1:0] in_op2,
  input  logic [W-1:0] in_y,
  input  logic         in_n,
  input  logic         in_v,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_res,
  output logic [W-1:0] out_y,
  output logic         out_n,
  output logic         out_z,
  output logic         out_v,
  output logic         out_c
);
  localparam int MSB = W - 1;

  logic [MSB:0]  partial;
  logic [MSB:0]  addend;
  logic [MSB:0]  sum;
  logic [MSB:0]  y_next;
  mstep_flags_t  flags_next;

  logic [MSB:0]  res_q;
  logic [MSB:0]  y_q;
  mstep_flags_t  flags_q;
  logic          valid_q;
  logic          take;

  mstep_operand #(.W(W)) u_operand (
    .op1_hi  (in_op1[MSB:1]),
    .op2     (in_op2),
    .y_lsb   (in_y[0]),
    .n_flag  (in_n),
    .v_flag  (in_v),
    .partial (partial),
    .addend  (addend)
  );

  mstep_adder #(.W(W)) u_adder (
    .partial (partial),
    .addend  (addend),
    .sum     (sum),
    .flags   (flags_next)
  );

  mstep_yshift #(.W(W)) u_yshift (
    .y_hi    (in_y[MSB:1]),
    .op1_lsb (in_op1[0]),
    .y_next  (y_next)
  );

  assign in_ready = !valid_q || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else if (in_ready) begin
      valid_q <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q   <= '0;
      y_q     <= '0;
      flags_q <= '0;
    end else if (take) begin
      res_q   <= sum;
      y_q     <= y_next;
      flags_q <= flags_next;
    end
  end

  assign out_valid = valid_q;
  assign out_res   = res_q;
  assign out_y     = y_q;
  assign out_n     = flags_q.n;
  assign out_z     = flags_q.z;
  assign out_v     = flags_q.v;
  assign out_c     = flags_q.c;
endmodule

// File: rtl/mstep_unit_chk.sv
module mstep_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_op1,
  input logic [W-1:0] in_op2,
  input logic [W-1:0] in_y,
  input logic         in_n,
  input logic         in_v,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_res,
  input logic [W-1:0] out_y,
  input logic         out_n,
  input logic         out_z,
  input logic         out_v,
  input logic         out_c
);
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R8

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_res) && $stable(out_y)
      && $stable({out_n, out_z, out_v, out_c})); // R8

  AST_Y_SHIFTED: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_y == {$past(in_op1[0]), $past(in_y[W-1:1])}); // R4

  AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_y[0] |=>
      out_res == {$past(in_n ^ in_v), $past(in_op1[W-1:1])} && !out_c && !out_v); // R2

  AST_ZERO_ADD_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op2 == '0 |=> !out_c); // R6

  AST_MIXED_SIGN_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_y[0] && (in_op2[W-1] != (in_n ^ in_v)) |=> !out_v); // R5

  AST_NEG_IS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_n == out_res[W-1]); // R7

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_z == (out_res == '0)); // R7
endmodule

bind mstep_unit mstep_unit_chk #(.W(W)) u_chk (.*);

// File: tb/mstep_unit_bench.sv
`timescale 1ns/1ps
module mstep_unit_bench;
  localparam int W = 32;

  typedef struct {
    logic [31:0] res;
    logic [31:0] y;
    bit n, z, v, c;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_op1 = '0, in_op2 = '0, in_y = '0;
  logic        in_n = 1'b0, in_v = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_res, out_y;
  logic        out_n, out_z, out_v, out_c;

  int checks = 0;
  int fails  = 0;
  exp_t q[$];
  bit   hold_prev = 0;
  exp_t held;

  always #4 clk = ~clk;

  mstep_unit #(.W(W)) u_mstep_unit (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_op1(in_op1), .in_op2(in_op2), .in_y(in_y), .in_n(in_n), .in_v(in_v),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_res(out_res), .out_y(out_y),
    .out_n(out_n), .out_z(out_z), .out_v(out_v), .out_c(out_c)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic exp_t ref_step(logic [31:0] a1, logic [31:0] a2, logic [31:0] ay, bit an, bit av);
    exp_t r;
    logic [63:0] part, add, s;
    part  = {32'd0, an ^ av, a1[31:1]};
    add   = ay[0] ? {32'd0, a2} : 64'd0;
    s     = part + add;
    r.res = s[31:0];
    r.c   = s[32];
    r.n   = s[31];
    r.z   = (s[31:0] == 32'd0);
    r.v   = (part[31] == add[31]) && (s[31] != add[31]);
    r.y   = {a1[0], ay[31:1]};
    return r;
  endfunction

  // Reference model, compared every clock.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (!rst_n) begin
        q.delete();
        hold_prev = 0;
      end else begin
        if (hold_prev) begin
          chk(out_valid && out_res == held.res && out_y == held.y, "R8 hold",
              {out_res, out_y}, {held.res, held.y});
        end
        chk(in_ready == (!out_valid || out_ready), "R8 ready", in_ready, !out_valid || out_ready);
        chk(out_valid == (q.size() != 0), "R8 valid", out_valid, q.size() != 0);
        if (out_valid && q.size() != 0) begin
          chk(out_res == q[0].res, "R3 result", out_res, q[0].res);
          chk(out_y == q[0].y, "R4 y", out_y, q[0].y);
          chk(out_v == q[0].v, "R5 v", out_v, q[0].v);
          chk(out_c == q[0].c, "R6 c", out_c, q[0].c);
          chk(out_n == q[0].n && out_z == q[0].z, "R7 nz", {out_n, out_z}, {q[0].n, q[0].z});
        end
        hold_prev = out_valid && !out_ready;
        held.res  = out_res;
        held.y    = out_y;
        if (out_valid && out_ready && q.size() != 0) void'(q.pop_front());
        if (in_valid && in_ready) q.push_back(ref_step(in_op1, in_op2, in_y, in_n, in_v));
      end
    end
  end

  task automatic step(input logic [31:0] a1, input logic [31:0] a2, input logic [31:0] ay,
                      input bit an, input bit av, output exp_t r);
    @(negedge clk);
    in_op1 = a1; in_op2 = a2; in_y = ay; in_n = an; in_v = av;
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    r.res = out_res; r.y = out_y; r.n = out_n; r.z = out_z; r.v = out_v; r.c = out_c;
  endtask

  task automatic mul_check(input logic [31:0] a, input logic [31:0] b);
    exp_t r;
    logic [31:0] p, yy, hi;
    bit nn, vv;
    longint prod;
    p = '0; yy = b; nn = 0; vv = 0;
    for (int i = 0; i < 32; i++) begin
      step(p, a, yy, nn, vv, r);
      p = r.res; yy = r.y; nn = r.n; vv = r.v;
    end
    step(p, 32'd0, yy, nn, vv, r);
    hi = r.res;
    if (b[31]) hi = hi - a;
    prod = longint'($signed(a)) * longint'($signed(b));
    chk({hi, r.y} == prod, "R10 product", {hi, r.y}, prod);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    exp_t r;
    // R9: reset state
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R9 valid in reset", out_valid, 0);
    chk(in_ready == 1'b1, "R9 ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(out_valid == 1'b0, "R9 valid after reset", out_valid, 0);

    // R2: Y[0]=0 leaves op2 out of the sum
    step(32'h0000_0004, 32'h1234_5678, 32'h0000_0002, 0, 0, r);
    chk(r.res == 32'h0000_0002, "R2 gated", r.res, 32'h2);
    // R1: N alone fills a 1
    step(32'h0000_0003, 32'h0, 32'h0, 1, 0, r);
    chk(r.res == 32'h8000_0001, "R1 fill one", r.res, 32'h8000_0001);
    chk(r.y == 32'h8000_0000, "R4 bit in", r.y, 32'h8000_0000);
    // R1: N and V both set fill a 0
    step(32'hFFFF_FFFF, 32'h0, 32'h0, 1, 1, r);
    chk(r.res == 32'h7FFF_FFFF, "R1 fill zero", r.res, 32'h7FFF_FFFF);
    // R5: positive overflow
    step(32'hFFFF_FFFE, 32'h1, 32'h1, 0, 0, r);
    chk(r.res == 32'h8000_0000 && r.v && !r.c && r.n, "R5 overflow",
        {r.res, r.v, r.c, r.n}, {32'h8000_0000, 3'b101});
    // R6/R7: wrap to zero with carry
    step(32'h0, 32'h8000_0000, 32'h1, 1, 0, r);
    chk(r.c && r.v, "R6 carry", {r.c, r.v}, 2'b11);
    chk(r.res == 0 && r.z && !r.n, "R7 zero", {r.res, r.z, r.n}, {32'h0, 2'b10});

    // Random stream with back-pressure on both sides
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      in_valid  = ($urandom_range(0, 9) < 6);
      out_ready = ($urandom_range(0, 9) < 7);
      in_op1 = $urandom; in_op2 = $urandom; in_y = $urandom;
      in_n = $urandom_range(0, 1); in_v = $urandom_range(0, 1);
    end
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);

    // R10: chained products
    mul_check(32'd3, 32'd5);
    mul_check(-32'sd7, 32'd9);
    mul_check(32'd123456, -32'sd789);
    mul_check(32'h8000_0000, 32'h8000_0000);
    mul_check(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    mul_check(32'h7FFF_FFFF, 32'h8000_0000);
    mul_check(32'd0, -32'sd5);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule